// File: doc/BRIEF.md
# Spatial Locality Buffer with Word Promotion

This block is a small, fully associative store of long lines that sits beside a main cache built from single-word lines. Every miss brings a whole long line into this buffer instead of the main cache. While a line stays resident, the buffer notes which of its words the processor actually reads. When the line is pushed out, only those words are handed to the main cache, one word at a time. The main cache therefore holds only words that have shown reuse. Words that were fetched for their neighbours and never touched are dropped.

A lookup is answered in the same cycle it is presented, and a hit marks the word as referenced. A line fill writes a complete long line in one cycle. When the buffer is full, the fill evicts the least recently used line. If that line has referenced words, the fill is held off while those words stream out on the promotion port. If it has none, the line is dropped and the fill is taken at once.

Top module: `spatial_buffer`

## Requirements
- R1: After reset every entry is empty: every lookup misses with `lkp_data` zero, `fill_ready` is 1 and `promo_valid` is 0.
- R2: A lookup with `lkp_valid` high hits in the same cycle when the upper `ADDR_W-3` address bits equal the tag of a resident line. `lkp_data` is then the word selected by address bits [2:0]. Otherwise `lkp_hit` is 0 and `lkp_data` is zero.
- R3: A fill while any entry is empty writes the lowest-numbered empty entry and is accepted in the cycle it is offered. Every fill clears all referenced-word marks of the entry it writes, so marks from that entry's previous line are never promoted.
- R4: When all entries are valid, a fill replaces the entry least recently touched. A touch is an accepted fill into the entry, or a lookup hit on it in a cycle with no accepted fill.
- R5: A lookup hit marks the addressed word as referenced. On eviction, each referenced word is promoted exactly once, in ascending word-offset order, with `promo_addr` = {victim tag, offset} and `promo_data` equal to that word.
- R6: While the replacement victim has referenced words, or a promotion is in progress, `fill_ready` is 0. The victim stops hitting from the cycle after promotion starts, and the fill is accepted in the first cycle after the last promoted word is taken.
- R7: The promotion port moves one word per cycle in which `promo_valid` and `promo_ready` are both high. While `promo_ready` is low, the offered address and data stay unchanged.
- R8: A victim with no referenced words is discarded: the fill is accepted in the cycle it is offered and nothing is promoted.
- R9: Repeated hits on the same word mark it only once, so that word is promoted a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_addr | input | ADDR_W | Word address of the lookup |
| lkp_hit | output | 1 | Lookup found its word in the buffer |
| lkp_data | output | DATA_W | Word returned on a hit, zero otherwise |
| fill_valid | input | 1 | A long line from memory is offered |
| fill_ready | output | 1 | The offered line is taken at this edge |
| fill_tag | input | ADDR_W-3 | Line address of the offered line |
| fill_line | input | WORDS*DATA_W | Line contents, word 0 in the low bits |
| promo_valid | output | 1 | A referenced word is offered to the main cache |
| promo_ready | input | 1 | The main cache takes the offered word |
| promo_addr | output | ADDR_W | Word address of the promoted word |
| promo_data | output | DATA_W | Promoted word |

## Verification
The hardest situation to reach is an eviction whose victim carries a sparse, non-contiguous set of marks, with the promotion port stalled and a lookup of the departing line made during the stall. The bench first fills the buffer and then shapes recency with lookups, so that a chosen line becomes the victim with chosen words marked. It revisits one word several times. It then offers the next fill while holding `promo_ready` low for a cycle, probes the victim's tag during promotion, and follows a chain of further fills. One of those fills lands in an entry whose earlier line had marks, which shows that the marks do not survive a refill.

// File: rtl/slb_pkg.sv
// Package: shared defaults and helpers for the spatial locality buffer.
// Assumes every vector passed to first_set is at most 32 bits wide.
package slb_pkg;
    localparam int SLB_ADDR_W  = 16;
    localparam int SLB_DATA_W  = 32;
    localparam int SLB_ENTRIES = 4;
    localparam int SLB_WORDS   = 8;

    // Position of the lowest set bit, zero when the vector is empty.
    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/slb_match.sv
// Module: tag comparators, one per entry, producing a hit vector and index.
// Assumes no two valid entries hold the same tag (fills occur only on misses).
module slb_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 13,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [TAG_W-1:0]   tags [ENTRIES],
    input  logic [TAG_W-1:0]   key,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [IDX_W-1:0]   hit_idx
);
    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tags[g] == key);
    end

    // Encode the matching entry number.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/slb_lru.sv
// Module: recency tracker built from per-entry ages that form a permutation.
// Age 0 is the most recent entry and age ENTRIES-1 the replacement victim.
// Assumes at most one touch per cycle.
module slb_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    // Age update: the touched entry becomes youngest and younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)        age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Locate the entry holding the oldest age.
    always_comb begin
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            oldest_vec[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
            if (oldest_vec[i]) victim = IDX_W'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec)); // R4
endmodule

// File: rtl/slb_promote.sv
// Module: promotion sequencer. Latches the victim's referenced-word mask and
// offers the lowest remaining offset each cycle on a valid/ready port.
// Assumes start is raised only while idle and only with a non-empty mask.
module slb_promote #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [WORDS-1:0] start_mask,
    input  logic             out_ready,
    output logic             busy,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [OFF_W-1:0] out_off
);
    logic [WORDS-1:0] mask_q;
    logic [WORDS-1:0] next_mask;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;

    // Pick the lowest outstanding word and the mask left after it goes.
    always_comb begin
        out_off   = OFF_W'(slb_pkg::first_set(32'(mask_q)));
        next_mask = mask_q;
        next_mask[out_off] = 1'b0;
    end

    // Sequencer state: load on start, drop one word per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mask_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            mask_q <= start_mask;
            idx_q  <= start_idx;
        end else if (busy_q && out_ready) begin
            mask_q <= next_mask;
            busy_q <= |next_mask;
        end
    end

    assign busy      = busy_q;
    assign out_valid = busy_q;
    assign out_idx   = idx_q;

    AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (mask_q != '0)); // R7
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_off) && $stable(out_idx))); // R7
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R6
endmodule

// File: rtl/spatial_buffer.sv
// Module: fully associative buffer of long lines with per-word reference marks.
// Lookups answer combinationally; fills take a whole line in one cycle; an
// evicted line's referenced words are promoted one per cycle to the main cache.
// Assumes fills are only offered for lines that are not already resident.
module spatial_buffer #(
    parameter int ADDR_W  = slb_pkg::SLB_ADDR_W,
    parameter int DATA_W  = slb_pkg::SLB_DATA_W,
    parameter int ENTRIES = slb_pkg::SLB_ENTRIES,
    parameter int WORDS   = slb_pkg::SLB_WORDS,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lkp_valid,
    input  logic [ADDR_W-1:0]       lkp_addr,
    output logic                    lkp_hit,
    output logic [DATA_W-1:0]       lkp_data,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [WORDS*DATA_W-1:0] fill_line,
    output logic                    promo_valid,
    input  logic                    promo_ready,
    output logic [ADDR_W-1:0]       promo_addr,
    output logic [DATA_W-1:0]       promo_data
);
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES][WORDS];
    logic [WORDS-1:0]   bits_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    logic [TAG_W-1:0]   lkp_tag;
    logic [OFF_W-1:0]   lkp_off;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [ENTRIES-1:0] empty_vec;
    logic               any_empty;
    logic [IDX_W-1:0]   first_empty;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   alloc_idx;
    logic               victim_marked;
    logic               busy;
    logic               fill_fire;
    logic               promo_start;
    logic               touch;
    logic [IDX_W-1:0]   touch_idx;
    logic [IDX_W-1:0]   p_idx;
    logic [OFF_W-1:0]   p_off;

    assign lkp_tag = lkp_addr[ADDR_W-1:OFF_W];
    assign lkp_off = lkp_addr[OFF_W-1:0];

    slb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .valid_vec (valid_q),
        .tags      (tag_q),
        .key       (lkp_tag),
        .hit_vec   (hit_vec),
        .hit_idx   (hit_idx)
    );

    // Lookup result: same-cycle hit and word select.
    always_comb begin
        lkp_hit  = lkp_valid && (|hit_vec);
        lkp_data = lkp_hit ? data_q[hit_idx][lkp_off] : '0;
    end

    // Allocation: lowest empty entry first, otherwise the recency victim.
    always_comb begin
        empty_vec     = ~valid_q;
        any_empty     = |empty_vec;
        first_empty   = IDX_W'(slb_pkg::first_set(32'(empty_vec)));
        alloc_idx     = any_empty ? first_empty : victim;
        victim_marked = !any_empty && (|bits_q[victim]);
        fill_ready    = !busy && !victim_marked;
        fill_fire     = fill_valid && fill_ready;
        promo_start   = fill_valid && !busy && victim_marked;
        touch         = fill_fire || lkp_hit;
        touch_idx     = fill_fire ? alloc_idx : hit_idx;
    end

    slb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    slb_promote #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_promote (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (promo_start),
        .start_idx  (victim),
        .start_mask (bits_q[victim]),
        .out_ready  (promo_ready),
        .busy       (busy),
        .out_valid  (promo_valid),
        .out_idx    (p_idx),
        .out_off    (p_off)
    );

    // Promotion payload read from the retired entry, which no fill may touch yet.
    assign promo_addr = {tag_q[p_idx], p_off};
    assign promo_data = data_q[p_idx][p_off];

    // Line storage: tag and words written on an accepted fill.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_fire && alloc_idx == IDX_W'(i)) begin
                tag_q[i] <= fill_tag;
                for (int w = 0; w < WORDS; w++) begin
                    data_q[i][w] <= fill_line[w*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Entry state: valid flags and reference marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) bits_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_fire && alloc_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    bits_q[i]  <= '0;
                end else if (promo_start && victim == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end else if (lkp_valid && hit_vec[i]) begin
                    bits_q[i][lkp_off] <= 1'b1;
                end
            end
        end
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2
    AST_MARKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> (bits_q[$past(alloc_idx)] == '0)); // R3
    AST_NO_FILL_DURING_PROMO: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> !fill_ready); // R6
    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_fire && !any_empty) |=> !promo_valid); // R8
    AST_RETIRED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        promo_start |=> !valid_q[$past(victim)]); // R6
endmodule

// File: tb/tb_spatial_buffer.sv
// Bench: directed scenarios, each task checks its own results.
module tb_spatial_buffer;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WORDS  = 8;
    localparam int TAG_W  = 13;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    lkp_valid = 1'b0;
    logic [ADDR_W-1:0]       lkp_addr = '0;
    logic                    lkp_hit;
    logic [DATA_W-1:0]       lkp_data;
    logic                    fill_valid = 1'b0;
    logic                    fill_ready;
    logic [TAG_W-1:0]        fill_tag = '0;
    logic [WORDS*DATA_W-1:0] fill_line = '0;
    logic                    promo_valid;
    logic                    promo_ready = 1'b1;
    logic [ADDR_W-1:0]       promo_addr;
    logic [DATA_W-1:0]       promo_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spatial_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_tag(fill_tag), .fill_line(fill_line),
        .promo_valid(promo_valid), .promo_ready(promo_ready),
        .promo_addr(promo_addr), .promo_data(promo_data)
    );

    function automatic logic [DATA_W-1:0] word_of(input int tag, input int w);
        return {8'hA5, 3'b000, TAG_W'(tag), 5'b00000, 3'(w)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Lookup one word and compare hit and data.
    task automatic look(input int tag, input int w, input bit exp_hit, input string req);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_addr  = {TAG_W'(tag), 3'(w)};
        #1;
        chk(lkp_hit == exp_hit, req, "lookup hit", 64'(lkp_hit), 64'(exp_hit));
        chk(lkp_data == (exp_hit ? word_of(tag, w) : '0), req, "lookup data",
            64'(lkp_data), 64'(exp_hit ? word_of(tag, w) : '0));
        @(posedge clk);
        #1 lkp_valid = 1'b0;
    endtask

    // Offer a line and follow any promotion of the expected victim words.
    task automatic fill(input int tag, input int vtag, input logic [WORDS-1:0] exp_mask,
                        input bit stall, input string req);
        logic [WORDS-1:0] left;
        bit               taken;
        left  = exp_mask;
        taken = 1'b0;
        @(negedge clk);
        fill_valid = 1'b1;
        fill_tag   = TAG_W'(tag);
        for (int w = 0; w < WORDS; w++) fill_line[w*DATA_W +: DATA_W] = word_of(tag, w);
        for (int cyc = 0; cyc < 40 && !taken; cyc++) begin
            if (cyc > 0) @(negedge clk);
            promo_ready = !(stall && cyc == 1);
            lkp_valid   = (exp_mask != '0) && cyc == 1;
            lkp_addr    = {TAG_W'(vtag), 3'd0};
            #1;
            if (cyc == 0)
                chk(fill_ready == (exp_mask == '0), req, "fill_ready on offer",
                    64'(fill_ready), 64'(exp_mask == '0));
            if (lkp_valid)
                chk(!lkp_hit, "R6", "victim hit during promotion", 64'(lkp_hit), 64'd0);
            if (promo_valid) begin
                int off;
                off = 0;
                for (int b = WORDS - 1; b >= 0; b--) if (left[b]) off = b;
                chk(left != '0, "R5", "unexpected promotion", 64'(promo_addr), 64'd0);
                chk(promo_addr == {TAG_W'(vtag), 3'(off)}, "R5", "promo_addr",
                    64'(promo_addr), 64'({TAG_W'(vtag), 3'(off)}));
                chk(promo_data == word_of(vtag, off), "R7", "promo_data",
                    64'(promo_data), 64'(word_of(vtag, off)));
                if (promo_ready) left[off] = 1'b0;
            end
            if (fill_ready) taken = 1'b1;
            @(posedge clk);
        end
        #1;
        fill_valid  = 1'b0;
        lkp_valid   = 1'b0;
        promo_ready = 1'b1;
        chk(taken, req, "fill accepted", 64'(taken), 64'd1);
        chk(left == '0, "R5", "words left unpromoted", 64'(left), 64'd0);
        @(negedge clk);
        chk(!promo_valid, "R8", "no promotion after fill", 64'(promo_valid), 64'd0);
        if (vtag != 0) look(vtag, 0, 1'b0, "R4");
    endtask

    task automatic t_reset();
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_addr  = 16'h0000;
        #1;
        chk(!lkp_hit && lkp_data == '0, "R1", "lookup after reset", 64'(lkp_hit), 64'd0);
        chk(fill_ready, "R1", "fill_ready after reset", 64'(fill_ready), 64'd1);
        chk(!promo_valid, "R1", "promo_valid after reset", 64'(promo_valid), 64'd0);
        lkp_valid = 1'b0;
    endtask

    task automatic t_fill_empty();
        for (int t = 1; t <= 4; t++) fill(t, 0, '0, 1'b0, "R3");
        look(2, 5, 1'b1, "R2");
        look(9, 0, 1'b0, "R2");
        look(1, 3, 1'b1, "R5");
        look(1, 6, 1'b1, "R5");
        look(1, 3, 1'b1, "R9");
    endtask

    task automatic t_discard_lru();
        fill(5, 3, '0, 1'b0, "R8");
        look(5, 2, 1'b1, "R4");
        look(4, 0, 1'b1, "R5");
        look(4, 7, 1'b1, "R5");
    endtask

    task automatic t_promote_stall();
        fill(6, 2, 8'b0010_0000, 1'b1, "R6");
    endtask

    task automatic t_promote_chain();
        fill(7, 1, 8'b0100_1000, 1'b0, "R9");
        fill(8, 5, 8'b0000_0100, 1'b0, "R5");
        fill(9, 4, 8'b1000_0001, 1'b0, "R5");
        fill(10, 6, '0, 1'b0, "R8");
        fill(11, 7, '0, 1'b0, "R3");
        look(10, 4, 1'b1, "R2");
        look(11, 7, 1'b1, "R2");
        look(1, 3, 1'b0, "R4");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_empty();
        t_discard_lru();
        t_promote_stall();
        t_promote_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule